// File: doc/BRIEF.md
# ADC Parallel Read Controller

This block connects a processor-style read bus to a 12-bit converter core. The host reads by pulling an active-low chip select and an active-low read strobe low together. Each such access also starts a conversion. The block brings both strobes into the system clock domain and detects the start of the access on the edge where the combined strobe becomes active. It keeps a busy flag for the fixed length of the conversion and puts the stored result on a 12-line output bus. That bus is enabled only during a qualified read.

A mode input, sampled once after reset, selects one of two read modes. In wait mode the host holds the strobes active. The bus stays disabled while the conversion runs and then returns the result of that same conversion. In ROM mode the bus is enabled at once with the result of the previous conversion, while the new conversion runs in the background. A high-byte enable input changes the output layout. When it is set, the top result nibble is driven on both the upper and lower nibble lines and the middle nibble lines are held at zero.

The converter core is a counter of fixed length. It captures the parallel sample input when a conversion starts and moves it to the result register when the conversion ends.

Top module: `adc_rd_ctrl`

## Requirements
- R1: An access is qualified only while cs_ni and rd_ni are both low. With either one high, data_oe_o stays 0, data_o stays 0 and no conversion starts.
- R2: A conversion starts once per access, on the synchronized edge where the combined strobe becomes active. Holding the strobes low for longer than a conversion does not start a second conversion.
- R3: busy_o rises 3 clock edges after both strobes go low (2 synchronizer stages plus 1 edge register). It then stays high for exactly CONV_CYCLES cycles (default 14).
- R4: A start that arrives while busy_o is high is ignored. The conversion in progress is neither lengthened nor restarted, and its result is the sample_i value captured at its own start.
- R5: The result register changes only on the cycle in which a conversion ends. It holds 0 after reset.
- R6: In wait mode (mode_rom_i = 0 at reset), data_oe_o is low whenever busy_o is high. A read returns the result of the conversion that the read itself started.
- R7: In ROM mode (mode_rom_i = 1 at reset), data_oe_o rises one cycle after the start is detected, which is 3 edges after the strobes fall. The bus then shows the result of the previous conversion.
- R8: With hben_i = 0 during a read, data_o[11:0] equals result[11:0].
- R9: With hben_i = 1 during a read, data_o[11:8] = result[11:8], data_o[7:4] = 0 and data_o[3:0] = result[11:8].
- R10: mode_rom_i is captured on the first clock edge after rst_ni is released. Later changes to it have no effect until the next reset.
- R11: While in reset, busy_o = 0, data_oe_o = 0 and data_o = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_rom_i | input | 1 | Read mode: 1 = ROM mode, 0 = wait mode; sampled after reset |
| cs_ni | input | 1 | Chip select, active low, asynchronous to clk_i |
| rd_ni | input | 1 | Read strobe, active low, asynchronous to clk_i |
| hben_i | input | 1 | High-byte layout select |
| sample_i | input | 12 | Parallel value the converter core captures at a start |
| busy_o | output | 1 | Conversion in progress |
| data_oe_o | output | 1 | Output enable for the data lines; 0 means high impedance |
| data_o | output | 12 | Data lines, forced to 0 when not enabled |

## Verification
The strobes pass through two synchronizer flops and an edge register, so busy_o and the ROM-mode enable both appear on the third edge after the strobes fall. In wait mode the enable appears CONV_CYCLES edges after that, on the same edge that clears busy_o and loads the result register. The driver pushes each expected bus word when it drops the strobes. The monitor samples on falling clock edges and compares the bus only on the cycle where data_oe_o rises, so the comparison happens exactly when the word is due, whatever the mode. Busy pulses are measured in the monitor by counting high samples between a rise and a fall, and ignored starts are seen from the stale data and from an unchanged pulse count.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic {
    MODE_WAIT = 1'b0,
    MODE_ROM  = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic rd_ni,
  output logic strb_o,
  output logic strb_dly_o,
  output logic rise_o
);
  logic              raw;
  logic [STAGES-1:0] sync_q;
  logic              dly_q;

  assign raw = ~cs_ni & ~rd_ni;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[0] <= 1'b0;
          else         sync_q[0] <= raw;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) sync_q[i] <= 1'b0;
          else         sync_q[i] <= sync_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dly_q <= 1'b0;
    else         dly_q <= sync_q[STAGES-1];
  end

  assign strb_o     = sync_q[STAGES-1];
  assign strb_dly_o = dly_q;
  assign rise_o     = sync_q[STAGES-1] & ~dly_q;
endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 1);

  logic              busy_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] samp_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      samp_q <= '0;
      res_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(CONV_CYCLES - 1);
      samp_q <= sample_i;
    end else if (busy_q) begin
      if (cnt_q == '0) begin
        busy_q <= 1'b0;
        res_q  <= samp_q;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign busy_o   = busy_q;
  assign result_o = res_q;
endmodule

// File: rtl/adc_bus_map.sv
module adc_bus_map #(
  parameter int unsigned DATA_W = 12
) (
  input  logic [DATA_W-1:0] result_i,
  input  logic              hben_i,
  input  logic              oe_i,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned HI_W = DATA_W / 3;

  logic [DATA_W-1:0] hb_map;

  generate
    for (genvar i = 0; i < DATA_W; i++) begin : g_line
      if (i >= DATA_W - HI_W) begin : g_hi
        assign hb_map[i] = result_i[i];
      end else if (i < HI_W) begin : g_lo
        assign hb_map[i] = result_i[DATA_W - HI_W + i];
      end else begin : g_mid
        assign hb_map[i] = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    if (!oe_i)       data_o = '0;
    else if (hben_i) data_o = hb_map;
    else             data_o = result_i;
  end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 14,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_rom_i,
  input  logic              cs_ni,
  input  logic              rd_ni,
  input  logic              hben_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              busy_o,
  output logic              data_oe_o,
  output logic [DATA_W-1:0] data_o
);
  rd_mode_e          mode_q;
  logic              mode_lock_q;
  logic              strb, strb_dly, strb_rise;
  logic              busy;
  logic [DATA_W-1:0] result_w;
  logic              oe;

  // mode captured once, on the first edge after reset release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q      <= MODE_WAIT;
      mode_lock_q <= 1'b0;
    end else if (!mode_lock_q) begin
      mode_q      <= rd_mode_e'(mode_rom_i);
      mode_lock_q <= 1'b1;
    end
  end

  adc_strobe_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_ni      (cs_ni),
    .rd_ni      (rd_ni),
    .strb_o     (strb),
    .strb_dly_o (strb_dly),
    .rise_o     (strb_rise)
  );

  adc_conv_seq #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) conv_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (strb_rise),
    .sample_i (sample_i),
    .busy_o   (busy),
    .result_o (result_w)
  );

  // strb_dly gate keeps the start cycle dark, before busy is visible
  assign oe = strb & strb_dly & ((mode_q == MODE_ROM) | ~busy);

  adc_bus_map #(.DATA_W(DATA_W)) map_i (
    .result_i (result_w),
    .hben_i   (hben_i),
    .oe_i     (oe),
    .data_o   (data_o)
  );

  assign busy_o    = busy;
  assign data_oe_o = oe;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk #(
  parameter int unsigned DATA_W      = 12,
  parameter int unsigned CONV_CYCLES = 14
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              rd_ni,
  input logic              hben_i,
  input logic              busy_o,
  input logic              data_oe_o,
  input logic [DATA_W-1:0] data_o,
  input logic              rom_mode,
  input logic [DATA_W-1:0] result_w
);
  localparam int unsigned CNT_W = $clog2(CONV_CYCLES + 2);

  logic [CNT_W-1:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     busy_cnt_q <= '0;
    else if (busy_o) busy_cnt_q <= busy_cnt_q + 1'b1;
    else             busy_cnt_q <= '0;
  end

  // R1
  oe_needs_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> $past(!cs_ni && !rd_ni, 2));

  // R1
  idle_bus_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == '0);

  // R3
  busy_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> busy_cnt_q == CNT_W'(CONV_CYCLES));

  // R4
  busy_no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> busy_cnt_q < CNT_W'(CONV_CYCLES));

  // R5
  result_at_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(result_w) |-> ($past(busy_o) && !busy_o));

  // R6
  wait_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rom_mode && busy_o) |-> !data_oe_o);

  // R9
  hben_map_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_oe_o && hben_i) |-> (data_o[7:4] == 4'h0 && data_o[3:0] == data_o[11:8]));
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cs_ni     (cs_ni),
  .rd_ni     (rd_ni),
  .hben_i    (hben_i),
  .busy_o    (busy_o),
  .data_oe_o (data_oe_o),
  .data_o    (data_o),
  .rom_mode  (mode_q == adc_rd_pkg::MODE_ROM),
  .result_w  (result_w)
);

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int N = 14;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode_rom_i = 1'b0;
  logic        cs_ni = 1'b1;
  logic        rd_ni = 1'b1;
  logic        hben_i = 1'b0;
  logic [11:0] sample_i = '0;
  logic        busy_o, data_oe_o;
  logic [11:0] data_o;

  int errors = 0;
  int checks = 0;
  int busy_rises = 0;
  logic [11:0] exp_q[$];
  string       tag_q[$];

  always #5 clk_i = ~clk_i;

  adc_rd_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_rom_i(mode_rom_i),
    .cs_ni(cs_ni), .rd_ni(rd_ni), .hben_i(hben_i), .sample_i(sample_i),
    .busy_o(busy_o), .data_oe_o(data_oe_o), .data_o(data_o)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic do_reset(logic rom);
    @(negedge clk_i);
    rst_ni = 1'b0; mode_rom_i = rom;
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R11 busy in reset", busy_o, 0);
    check("R11 oe in reset", data_oe_o, 0);
    check("R11 data in reset", data_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
  endtask

  task automatic do_read(logic [11:0] samp, logic hb, int hold, int gap,
                         logic [11:0] exp, string tag);
    @(negedge clk_i);
    sample_i = samp; hben_i = hb;
    exp_q.push_back(exp); tag_q.push_back(tag);
    cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (hold) @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (gap) @(negedge clk_i);
  endtask

  // monitor: compare on the cycle the bus turns on; measure busy pulses
  initial begin
    logic prev_oe = 1'b0;
    logic prev_busy = 1'b0;
    int   blen = 0;
    forever begin
      @(negedge clk_i);
      if (!rst_ni) begin
        prev_oe = 1'b0; prev_busy = 1'b0; blen = 0;
      end else begin
        if (data_oe_o && !prev_oe) begin
          if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R1 unexpected bus enable: actual=%0h expected=none", data_o);
          end else begin
            check(tag_q.pop_front(), data_o, exp_q.pop_front());
          end
        end
        if (busy_o) blen++;
        if (busy_o && !prev_busy) busy_rises++;
        if (!busy_o && prev_busy) begin
          check("R3 busy length", blen, N);
          blen = 0;
        end
        prev_oe = data_oe_o; prev_busy = busy_o;
      end
    end
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    summary();
  end

  initial begin
    int r0;
    // ROM mode
    do_reset(1'b1);
    // R1: partial strobes do nothing
    cs_ni = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R1 cs only busy", busy_o, 0);
    check("R1 cs only oe", data_oe_o, 0);
    cs_ni = 1'b1; rd_ni = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R1 rd only busy", busy_o, 0);
    check("R1 rd only data", data_o, 0);
    rd_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    // R3: busy timing after strobe fall
    @(negedge clk_i);
    sample_i = 12'hABC; hben_i = 1'b0;
    exp_q.push_back(12'h000); tag_q.push_back("R7 R5 rom first read returns reset result");
    cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R3 busy not yet at 2 edges", busy_o, 0);
    @(negedge clk_i);
    check("R3 busy at 3 edges", busy_o, 1);
    check("R7 oe at 3 edges", data_oe_o, 1);
    @(negedge clk_i);
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (20) @(negedge clk_i);
    // R10: later mode change ignored
    mode_rom_i = 1'b0;
    do_read(12'h123, 1'b1, 4, 2, 12'hA0A, "R9 R10 rom hben stale");
    // R4: start while busy ignored
    r0 = busy_rises;
    do_read(12'h555, 1'b0, 4, 25, 12'hABC, "R4 R8 read during busy stale");
    check("R4 one conversion only", busy_rises - r0, 0);
    do_read(12'h777, 1'b0, 4, 20, 12'h123, "R4 R7 ignored sample not stored");
    // R2: long hold, single start
    r0 = busy_rises;
    do_read(12'h246, 1'b0, 40, 5, 12'h777, "R2 R7 long hold");
    check("R2 single start per access", busy_rises - r0, 1);

    // wait mode
    do_reset(1'b0);
    do_read(12'h9F6, 1'b0, N + 8, 4, 12'h9F6, "R6 R8 wait fresh result");
    @(negedge clk_i);
    sample_i = 12'h5A3; hben_i = 1'b1;
    exp_q.push_back(12'h505); tag_q.push_back("R6 R9 wait hben fresh");
    cs_ni = 1'b0; rd_ni = 1'b0;
    repeat (8) @(negedge clk_i);
    check("R6 oe dark while busy", data_oe_o, 0);
    check("R6 busy during wait", busy_o, 1);
    repeat (N + 2) @(negedge clk_i);
    check("R6 oe on after end", data_oe_o, 1);
    cs_ni = 1'b1; rd_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    do_read(12'hFFF, 1'b0, N + 8, 4, 12'hFFF, "R8 wait all ones");
    do_read(12'h000, 1'b0, N + 8, 4, 12'h000, "R8 wait all zeros");
    check("R1 bus idle after reads", data_o, 0);
    check("scoreboard drained", exp_q.size(), 0);
    summary();
  end
endmodule